// File: doc/BRIEF.md
# Protocol Controller Command Interface

This block is the host-facing command port of a time-triggered bus protocol controller. The host writes a 4-bit command code into a control register over a simple register bus. A protocol-state sequencer accepts or rejects each command against the current controller state. After an accepted command, the port stays busy for a fixed number of clock cycles. Command writes made while it is busy are ignored. Reading back the command field shows the code of the last command that was taken, or zero if it was refused.

The sequencer tracks six controller states and publishes a 6-bit state code. Leaving the configuration state is guarded: two bytes must be written to a key register, and the READY command must be the very next register write. A startup phase ends on one of two external pulses, one modelling integration success and one modelling failure. Each failure spends one of the remaining coldstart attempts. A halt request waits for the end of the current communication cycle before it takes effect.

Top module: `pcc_cmd_if`

## Requirements
- R1: After reset, the state code is 0x0F (configuration) and busy is 0. The command readback is 0, the coldstart-attempt count equals CS_INIT (default 8) and the coldstart-inhibit flag is 1.
- R2: A write to the control register (address 0) carries a command code in bits 3:0. If the command is accepted, bits 3:0 read back that code. If it is rejected, they read back 0, the state does not change and busy stays 0.
- R3: Busy is bit 7 of the control register. While busy is 1, a control write is ignored: the readback and the state stay as they were.
- R4: READY (code 2) leaves configuration only when the three preceding register writes go in this order: 0xCE to the key register (address 1, bits 7:0), then 0x31 to the key register, then READY as the very next register write. Any other write in between, to any address, breaks the sequence, and the READY is then rejected.
- R5: The state code appears on state_code and in bits 5:0 of the status register (address 2). The codes are: configuration 0x0F, ready 0x01, startup 0x20, integration-listen 0x27, normal-active 0x02, halt 0x03.
- R6: An accepted command raises busy for exactly BUSY_CYC clock cycles (default 4), after which busy clears.
- R7: RUN (code 4) moves ready to startup. READY moves startup, integration-listen or normal-active back to ready.
- R8: In startup, an integration-success pulse moves the state to normal-active. An integration-failure pulse moves it to integration-listen and lowers the attempt count (status bits 12:8) by one, stopping at 0. An accepted command in the same cycle takes precedence over either pulse.
- R9: ALLOW_CS (code 5) is accepted in ready, startup, integration-listen and normal-active. It clears the coldstart-inhibit flag (status bit 16).
- R10: HALT (code 6) is accepted only in normal-active. The state changes to halt only on a cycle-end pulse that comes after the HALT was accepted.
- R11: CONFIG (code 1) is accepted in ready or halt. It returns the state to configuration and sets the inhibit flag. Entering ready from configuration reloads the attempt count to CS_INIT.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address (0 control, 1 key, 2 status) |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data for rd_addr, combinational |
| integ_ok | input | 1 | Integration success pulse during startup |
| integ_fail | input | 1 | Integration failure pulse during startup |
| cycle_end | input | 1 | End of a communication cycle |
| state_code | output | 6 | Current controller state code |
| busy | output | 1 | Command port busy |

## Verification
The assertions assume that reset is held for at least one clock edge before any other activity. The pulse checks assume that the integration and cycle-end inputs are single-cycle pulses. The bench drives at most one register write per cycle and raises each pulse for exactly one cycle. It never raises integ_ok and integ_fail together, and it places no pulse in the same cycle as a control write. The R8 precedence rule therefore applies only by design and is not exercised.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_KEY  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    localparam logic [7:0] KEY_FIRST  = 8'hCE;
    localparam logic [7:0] KEY_SECOND = 8'h31;

    typedef enum logic [5:0] {
        ST_CONFIG  = 6'h0F,
        ST_READY   = 6'h01,
        ST_NORMAL  = 6'h02,
        ST_HALT    = 6'h03,
        ST_STARTUP = 6'h20,
        ST_LISTEN  = 6'h27
    } poc_state_e;

    typedef enum logic [3:0] {
        CMD_NONE     = 4'd0,
        CMD_CONFIG   = 4'd1,
        CMD_READY    = 4'd2,
        CMD_RUN      = 4'd4,
        CMD_ALLOW_CS = 4'd5,
        CMD_HALT     = 4'd6
    } cmd_e;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_e;

    typedef struct packed {
        logic       valid;
        logic [3:0] code;
    } cmd_req_t;

    function automatic logic cmd_ok(poc_state_e st, logic [3:0] code, logic armed);
        logic ok;
        ok = 1'b0;
        case (code)
            CMD_CONFIG:   ok = (st == ST_READY) || (st == ST_HALT);
            CMD_READY:    ok = ((st == ST_CONFIG) && armed) || (st == ST_STARTUP) ||
                               (st == ST_LISTEN) || (st == ST_NORMAL);
            CMD_RUN:      ok = (st == ST_READY);
            CMD_ALLOW_CS: ok = (st == ST_READY) || (st == ST_STARTUP) ||
                               (st == ST_LISTEN) || (st == ST_NORMAL);
            CMD_HALT:     ok = (st == ST_NORMAL);
            default:      ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pcc_unlock.sv
module pcc_unlock
    import pcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       any_wr,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    output logic       armed
);
    unlock_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (any_wr) begin
            if (!key_wr) begin
                st_d = UL_IDLE;
            end else if (st_q == UL_HALF) begin
                st_d = (key_byte == KEY_SECOND) ? UL_ARMED : UL_IDLE;
            end else begin
                st_d = (key_byte == KEY_FIRST) ? UL_HALF : UL_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= UL_IDLE;
        else     st_q <= st_d;
    end

    assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/pcc_busy_timer.sv
module pcc_busy_timer #(
    parameter int BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(BUSY_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/pcc_poc_seq.sv
module pcc_poc_seq
    import pcc_pkg::*;
#(
    parameter int CSW     = 5,
    parameter int CS_INIT = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  cmd_req_t       req,
    input  logic           armed,
    input  logic           integ_ok,
    input  logic           integ_fail,
    input  logic           cycle_end,
    output poc_state_e     state,
    output logic           accept,
    output logic [3:0]     cmd_rb,
    output logic [CSW-1:0] attempts,
    output logic           inhibit
);
    localparam logic [CSW-1:0] ATT_INIT = CSW'(CS_INIT);

    logic halt_pend;

    assign accept = req.valid && cmd_ok(state, req.code, armed);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_CONFIG;
            cmd_rb    <= 4'd0;
            attempts  <= ATT_INIT;
            inhibit   <= 1'b1;
            halt_pend <= 1'b0;
        end else begin
            if (req.valid) cmd_rb <= accept ? req.code : 4'd0;
            if (accept) begin
                case (req.code)
                    CMD_CONFIG: begin
                        state     <= ST_CONFIG;
                        inhibit   <= 1'b1;
                        halt_pend <= 1'b0;
                    end
                    CMD_READY: begin
                        if (state == ST_CONFIG) attempts <= ATT_INIT;
                        state     <= ST_READY;
                        halt_pend <= 1'b0;
                    end
                    CMD_RUN:      state     <= ST_STARTUP;
                    CMD_ALLOW_CS: inhibit   <= 1'b0;
                    CMD_HALT:     halt_pend <= 1'b1;
                    default:      ;
                endcase
            end else if (state == ST_STARTUP && integ_ok) begin
                state <= ST_NORMAL;
            end else if (state == ST_STARTUP && integ_fail) begin
                state <= ST_LISTEN;
                if (attempts != '0) attempts <= attempts - 1'b1;
            end else if (halt_pend && cycle_end) begin
                state     <= ST_HALT;
                halt_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pcc_cmd_if.sv
module pcc_cmd_if
    import pcc_pkg::*;
#(
    parameter int AW       = 2,
    parameter int DW       = 32,
    parameter int BUSY_CYC = 4,
    parameter int CSW      = 5,
    parameter int CS_INIT  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          integ_ok,
    input  logic          integ_fail,
    input  logic          cycle_end,
    output logic [5:0]    state_code,
    output logic          busy
);
    localparam int BUSY_BIT = 7;
    localparam int ATT_LSB  = 8;
    localparam int INH_BIT  = 16;

    logic           key_armed;
    logic           accept;
    logic [3:0]     cmd_rb;
    logic [CSW-1:0] attempts;
    logic           inhibit;
    poc_state_e     state;
    cmd_req_t       req;

    assign req.valid = wr_en && (wr_addr == AW'(ADDR_CTRL)) && !busy;
    assign req.code  = wr_data[3:0];

    pcc_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .any_wr   (wr_en),
        .key_wr   (wr_addr == AW'(ADDR_KEY)),
        .key_byte (wr_data[7:0]),
        .armed    (key_armed)
    );

    pcc_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .busy (busy)
    );

    pcc_poc_seq #(.CSW(CSW), .CS_INIT(CS_INIT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .armed      (key_armed),
        .integ_ok   (integ_ok),
        .integ_fail (integ_fail),
        .cycle_end  (cycle_end),
        .state      (state),
        .accept     (accept),
        .cmd_rb     (cmd_rb),
        .attempts   (attempts),
        .inhibit    (inhibit)
    );

    assign state_code = state;

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_CTRL)) begin
            rd_data[3:0]     = cmd_rb;
            rd_data[BUSY_BIT] = busy;
        end else if (rd_addr == AW'(ADDR_STAT)) begin
            rd_data[5:0]                 = state;
            rd_data[ATT_LSB +: CSW]      = attempts;
            rd_data[INH_BIT]             = inhibit;
        end
    end
endmodule

// File: rtl/pcc_cmd_if_chk.sv
module pcc_cmd_if_chk
    import pcc_pkg::*;
#(
    parameter int AW       = 2,
    parameter int BUSY_CYC = 4,
    parameter int CSW      = 5
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_en,
    input logic [AW-1:0]  wr_addr,
    input logic [5:0]     state_code,
    input logic           busy,
    input logic [3:0]     cmd_rb,
    input logic           armed,
    input logic [CSW-1:0] attempts,
    input logic           cycle_end
);
    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)            busy_run <= '0;
        else if (!busy)     busy_run <= '0;
        else if (busy_run != 16'hFFFF) busy_run <= busy_run + 1'b1;
    end

    p_busy_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && wr_addr == AW'(ADDR_CTRL)) |=> $stable(cmd_rb));

    p_cfg_exit_key_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(state_code) == ST_CONFIG && state_code == ST_READY) |-> $past(armed));

    p_legal_code_r5: assert property (@(posedge clk) disable iff (rst)
        state_code inside {ST_CONFIG, ST_READY, ST_NORMAL, ST_HALT, ST_STARTUP, ST_LISTEN});

    p_busy_bound_r6: assert property (@(posedge clk) disable iff (rst)
        busy_run <= 16'(BUSY_CYC));

    p_fail_dec_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(state_code) == ST_STARTUP && state_code == ST_LISTEN) |->
        (attempts == (($past(attempts) == '0) ? '0 : $past(attempts) - 1'b1)));

    p_halt_wait_r10: assert property (@(posedge clk) disable iff (rst)
        (state_code == ST_HALT && $past(state_code) != ST_HALT) |-> $past(cycle_end));
endmodule

bind pcc_cmd_if pcc_cmd_if_chk #(.AW(AW), .BUSY_CYC(BUSY_CYC), .CSW(CSW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .state_code (state_code),
    .busy       (busy),
    .cmd_rb     (cmd_rb),
    .armed      (key_armed),
    .attempts   (attempts),
    .cycle_end  (cycle_end)
);

// File: tb/pcc_cmd_if_bench.sv
module pcc_cmd_if_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 4;
    localparam int CS_INIT    = 8;

    localparam logic [31:0] M_CMD  = 32'h0000_000F;
    localparam logic [31:0] M_CTRL = 32'h0000_008F;
    localparam logic [31:0] M_STAT = 32'h0001_1F3F;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        integ_ok, integ_fail, cycle_end;
    logic [5:0]  state_code;
    logic        busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcc_cmd_if #(.BUSY_CYC(BUSY), .CS_INIT(CS_INIT)) u_pcc_cmd_if (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .integ_ok(integ_ok),
        .integ_fail(integ_fail), .cycle_end(cycle_end),
        .state_code(state_code), .busy(busy)
    );

    int total = 0;
    int bad   = 0;
    int pending = 0;
    bit finished = 0;

    logic [1:0]  q_addr[$];
    logic [31:0] q_mask[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];
    event        chk_ev;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] stat_word(logic [5:0] st, logic [4:0] att, logic inh);
        return {15'd0, inh, 3'd0, att, 2'd0, st};
    endfunction

    task automatic expect_reg(logic [1:0] a, logic [31:0] m, logic [31:0] e, string tag);
        q_addr.push_back(a);
        q_mask.push_back(m);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        pending++;
    endtask

    task automatic flush();
        ->chk_ev;
        wait (pending == 0);
    endtask

    // monitor: pops expected items and compares against the read port
    initial begin
        rd_addr = 2'd0;
        forever begin
            @(chk_ev);
            while (q_exp.size() != 0) begin
                logic [1:0]  a;
                logic [31:0] m, e;
                string t;
                a = q_addr.pop_front();
                m = q_mask.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                rd_addr = a;
                #1;
                check(t, rd_data & m, e & m);
                pending--;
            end
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        if (which == 0) integ_ok = 1'b1;
        else if (which == 1) integ_fail = 1'b1;
        else cycle_end = 1'b1;
        @(negedge clk);
        integ_ok = 1'b0; integ_fail = 1'b0; cycle_end = 1'b0;
    endtask

    task automatic unlock_ready();
        wr(2'd1, 32'hCE);
        wr(2'd1, 32'h31);
        wr(2'd0, 32'd2);
        wait_idle();
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        integ_ok = 1'b0; integ_fail = 1'b0; cycle_end = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        expect_reg(2'd0, M_CTRL, 32'd0, "R1 ctrl");
        expect_reg(2'd2, M_STAT, stat_word(6'h0F, 5'd8, 1'b1), "R1 status");
        flush();

        // R4 READY without key, R2 rejection reads zero
        wr(2'd0, 32'd2);
        check("R2 no busy on reject", {31'd0, busy}, 32'd0);
        expect_reg(2'd0, M_CMD, 32'd0, "R4 ready no key");
        expect_reg(2'd2, 32'h3F, 32'h0F, "R4 still config");
        flush();

        // R4 wrong byte between key halves
        wr(2'd1, 32'hCE); wr(2'd1, 32'h00); wr(2'd1, 32'h31); wr(2'd0, 32'd2);
        expect_reg(2'd2, 32'h3F, 32'h0F, "R4 broken key");
        flush();

        // R4 foreign write after the key
        wr(2'd1, 32'hCE); wr(2'd1, 32'h31); wr(2'd2, 32'h0); wr(2'd0, 32'd2);
        expect_reg(2'd2, 32'h3F, 32'h0F, "R4 stale key");
        flush();

        // R4 good key, R3 command while busy is ignored
        wr(2'd1, 32'hCE); wr(2'd1, 32'h31); wr(2'd0, 32'd2);
        check("R3 busy after accept", {31'd0, busy}, 32'd1);
        wr(2'd0, 32'd4);
        expect_reg(2'd0, M_CTRL, 32'h82, "R3 readback during busy");
        expect_reg(2'd2, 32'h3F, 32'h01, "R4 ready reached");
        flush();
        wait_idle();
        check("R3 state unchanged", {26'd0, state_code}, 32'h01);

        // R10 halt rejected outside normal-active
        wr(2'd0, 32'd6);
        expect_reg(2'd0, M_CMD, 32'd0, "R10 halt in ready");
        flush();

        // R2/R7 RUN
        wr(2'd0, 32'd4); wait_idle();
        expect_reg(2'd0, M_CMD, 32'd4, "R2 run readback");
        expect_reg(2'd2, 32'h3F, 32'h20, "R7 startup");
        flush();

        // R8 failure
        pulse(1);
        expect_reg(2'd2, M_STAT, stat_word(6'h27, 5'd7, 1'b1), "R8 listen dec");
        flush();

        // R9 allow coldstart, R6 busy length
        wr(2'd0, 32'd5);
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        check("R6 busy cycles", cnt, BUSY);
        expect_reg(2'd2, M_STAT, stat_word(6'h27, 5'd7, 1'b0), "R9 inhibit clear");
        flush();

        // R7 back to ready, then success path
        wr(2'd0, 32'd2); wait_idle();
        check("R7 listen to ready", {26'd0, state_code}, 32'h01);
        wr(2'd0, 32'd4); wait_idle();
        pulse(0);
        check("R8 normal active", {26'd0, state_code}, 32'h02);

        // R10 halt waits for cycle end
        wr(2'd0, 32'd6); wait_idle();
        repeat (3) @(negedge clk);
        expect_reg(2'd0, M_CMD, 32'd6, "R10 halt accepted");
        expect_reg(2'd2, 32'h3F, 32'h02, "R10 waits");
        flush();
        pulse(2);
        check("R10 halted", {26'd0, state_code}, 32'h03);

        // R11 config from halt
        wr(2'd0, 32'd1); wait_idle();
        expect_reg(2'd2, M_STAT, stat_word(6'h0F, 5'd7, 1'b1), "R11 config");
        flush();

        // R8 saturation, R11 reload
        unlock_ready();
        expect_reg(2'd2, M_STAT, stat_word(6'h01, 5'd8, 1'b1), "R11 reload");
        flush();
        for (int i = 0; i < CS_INIT + 1; i++) begin
            wr(2'd0, 32'd4); wait_idle();
            pulse(1);
            wr(2'd0, 32'd2); wait_idle();
        end
        expect_reg(2'd2, M_STAT, stat_word(6'h01, 5'd0, 1'b1), "R8 saturate");
        expect_reg(2'd0, M_CTRL, 32'h02, "R5 ctrl idle");
        flush();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule